// File: doc/BRIEF.md
# Single-Clock FIFO with SECDED Word Protection

This block is a synchronous first-in first-out buffer whose storage holds every word in protected form. On its way in, each data word is widened with Hamming check bits and one overall parity bit. The word coming out of storage is decoded before it is presented, so a single flipped bit is repaired silently and reported, and a pair of flipped bits is reported as uncorrectable.

Writes and reads are qualified by the flow flags: a write is taken only when the buffer is not full, and a read is taken only when it is not empty. Read results are registered and appear on the clock edge after the accepted read. Between reads they hold their value. A bit-flip mask input is XORed onto the stored word as it leaves storage. A test environment uses it to inject zero, one or two bit errors at any chosen position.

Top module: `ecc_fifo`

## Requirements
- R1: While the active-low reset is held and right after it is released, empty is 1, full is 0, rd_data is 0 and both rd_error and rd_corrected are 0.
- R2: A word read with an all-zero flip mask equals the word written, with rd_error = 0 and rd_corrected = 0.
- R3: A read whose flip mask has exactly one bit set, at any of the 13 stored-bit positions (bit 0 is the overall parity bit and bits 1..12 are Hamming positions 1..12), returns the original word with rd_corrected = 1 and rd_error = 0.
- R4: A read whose flip mask has exactly two bits set gives rd_error = 1 and rd_corrected = 0. The two flags are never both 1.
- R5: rd_data, rd_error and rd_corrected change only on the clock edge that follows an accepted read, and otherwise hold their values.
- R6: After DEPTH accepted writes with no reads, starting from empty, full is 1. It is 0 after DEPTH-1 such writes. full and empty are never 1 together.
- R7: empty falls on the edge after any accepted write. After as many reads as there are stored words, with no writes, empty is 1.
- R8: A write while full is ignored. full stays 1, and draining returns exactly the DEPTH earlier words in order.
- R9: A read while empty is ignored. The outputs hold, empty stays 1, and the next word written is the next word read.
- R10: A cycle with both a read and a write on a buffer that is neither empty nor full leaves the occupancy unchanged and preserves first-in first-out order.
- R11: The flip mask acts only in a cycle where a read is accepted. A mask applied during writes or idle cycles has no effect on later clean reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free entry |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Decoded read word, registered |
| empty | output | 1 | No stored entry |
| rd_error | output | 1 | Uncorrectable (double) error on last read |
| rd_corrected | output | 1 | Single error repaired on last read |
| flip_mask | input | DATA_W+CHK_W+1 | Bits XORed onto the stored word on the read path |

## Verification
The decoder is exercised with a clean mask, then with a single flip walked across all 13 stored positions including the overall parity bit, then with flip pairs that mix check, data and parity positions. The walked single flips separate a correct syndrome-to-position mapping from an off-by-one or a missed parity-bit case. The pairs separate true double detection from a wrong correction. Flow control is tried with a fill to exactly DEPTH plus one extra write, a full drain plus extra reads, and back-to-back combined read/write cycles. These show whether the wrap bit, the ignore rules and the occupancy arithmetic are right.

// File: rtl/ecc_fifo_pkg.sv
package ecc_fifo_pkg;

   typedef enum logic [1:0] {
      DEC_CLEAN = 2'd0,
      DEC_FIXED = 2'd1,
      DEC_FATAL = 2'd2
   } dec_stat_e;

   // number of Hamming check bits needed to cover w data bits
   function automatic int hamming_chk(input int w);
      int p;
      p = 1;
      while ((1 << p) < (w + p + 1)) p++;
      return p;
   endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc #(
   parameter int DATA_W = 8,
   parameter int CHK_W  = 4,
   localparam int HAM_W  = DATA_W + CHK_W,
   localparam int CODE_W = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CODE_W-1:0] code_o
);

   logic [CODE_W-1:0] cw;

   always_comb begin
      int  k;
      logic acc;
      cw = '0;
      k  = 0;
      // data fills the non-power-of-two positions in ascending order
      for (int pos = 1; pos <= HAM_W; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            cw[pos] = data_i[k];
            k++;
         end
      end
      for (int j = 0; j < CHK_W; j++) begin
         acc = 1'b0;
         for (int pos = 1; pos <= HAM_W; pos++) begin
            if ((((pos >> j) & 1) == 1) && (pos != (1 << j))) acc = acc ^ cw[pos];
         end
         cw[1 << j] = acc;
      end
      cw[0] = ^cw[HAM_W:1];
   end

   assign code_o = cw;

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
   import ecc_fifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CHK_W  = 4,
   localparam int HAM_W  = DATA_W + CHK_W,
   localparam int CODE_W = HAM_W + 1
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [DATA_W-1:0] data_o,
   output dec_stat_e         stat_o
);

   function automatic logic [CODE_W-1:0] cover_mask(input int j);
      logic [CODE_W-1:0] m;
      m = '0;
      for (int pos = 1; pos <= HAM_W; pos++) begin
         if (((pos >> j) & 1) == 1) m[pos] = 1'b1;
      end
      return m;
   endfunction

   logic [CHK_W-1:0]  syn;
   logic              par_odd;
   logic [CODE_W-1:0] fixed;

   for (genvar j = 0; j < CHK_W; j++) begin : g_syn
      localparam logic [CODE_W-1:0] COVER = cover_mask(j);
      assign syn[j] = ^(code_i & COVER);
   end

   assign par_odd = ^code_i;

   always_comb begin
      fixed  = code_i;
      stat_o = DEC_CLEAN;
      if (par_odd) begin
         if (int'(syn) <= HAM_W) begin
            // zero syndrome points at the overall parity bit itself
            fixed[syn] = ~code_i[syn];
            stat_o     = DEC_FIXED;
         end else begin
            stat_o = DEC_FATAL;
         end
      end else if (syn != '0) begin
         stat_o = DEC_FATAL;
      end
   end

   always_comb begin
      int k;
      data_o = '0;
      k      = 0;
      for (int pos = 1; pos <= HAM_W; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            data_o[k] = fixed[pos];
            k++;
         end
      end
   end

endmodule

// File: rtl/fifo_ptr_ctl.sv
module fifo_ptr_ctl #(
   parameter int DEPTH = 32,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic          wr_ok,
   output logic          rd_ok,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic          full,
   output logic          empty
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fifo_ptr_ctl: DEPTH must be a power of two of at least 2");
   end

   logic [AW:0] wptr, rptr;
   logic [AW:0] occ;

   assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
   assign empty   = (wptr == rptr);
   assign wr_ok   = wr_en && !full;
   assign rd_ok   = rd_en && !empty;
   assign wr_addr = wptr[AW-1:0];
   assign rd_addr = rptr[AW-1:0];
   assign occ     = wptr - rptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (wr_ok) wptr <= wptr + 1'b1;
         if (rd_ok) rptr <= rptr + 1'b1;
      end
   end

   AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R6
   AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> !empty); // R7
   AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en) |=> (full && $stable(wptr))); // R8
   AST_EMPTY_READ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en && !wr_en) |=> (empty && $stable(rptr))); // R9
   AST_OCC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && rd_ok) |=> $stable(occ)); // R10

endmodule

// File: rtl/ecc_fifo.sv
module ecc_fifo
   import ecc_fifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32,
   localparam int CHK_W  = hamming_chk(DATA_W),
   localparam int CODE_W = DATA_W + CHK_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              rd_error,
   output logic              rd_corrected,
   input  logic [CODE_W-1:0] flip_mask
);

   localparam int AW = $clog2(DEPTH);

   if (DATA_W < 1) begin : g_bad_width
      $error("ecc_fifo: DATA_W must be at least 1");
   end

   logic              wr_ok, rd_ok;
   logic [AW-1:0]     wr_addr, rd_addr;
   logic [CODE_W-1:0] enc_word, raw_word, hit_word;
   logic [DATA_W-1:0] dec_data;
   dec_stat_e         dec_stat;
   logic [CODE_W-1:0] store [DEPTH];

   fifo_ptr_ctl #(.DEPTH(DEPTH)) ptr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .wr_ok   (wr_ok),
      .rd_ok   (rd_ok),
      .wr_addr (wr_addr),
      .rd_addr (rd_addr),
      .full    (full),
      .empty   (empty)
   );

   ecc_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) enc_i (
      .data_i (wr_data),
      .code_o (enc_word)
   );

   always_ff @(posedge clk) begin
      if (wr_ok) store[wr_addr] <= enc_word;
   end

   assign raw_word = store[rd_addr];
   assign hit_word = raw_word ^ flip_mask;

   ecc_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) dec_i (
      .code_i (hit_word),
      .data_o (dec_data),
      .stat_o (dec_stat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data      <= '0;
         rd_error     <= 1'b0;
         rd_corrected <= 1'b0;
      end else if (rd_ok) begin
         rd_data      <= dec_data;
         rd_error     <= (dec_stat == DEC_FATAL);
         rd_corrected <= (dec_stat == DEC_FIXED);
      end
   end

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_error && rd_corrected)); // R4
   AST_CLEAN_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ok && flip_mask == '0) |=> (!rd_error && !rd_corrected)); // R2
   AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ok |=> ($stable(rd_data) && $stable(rd_error) && $stable(rd_corrected))); // R5

endmodule

// File: tb/ecc_fifo_tb_top.sv
module ecc_fifo_tb_top;

   localparam int DW    = 8;
   localparam int DEPTH = 32;
   localparam int CW    = DW + ecc_fifo_pkg::hamming_chk(DW) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [CW-1:0] flip_mask = '0;
   logic          full, empty, rd_error, rd_corrected;
   logic [DW-1:0] rd_data;

   always #4 clk = ~clk;

   ecc_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .full         (full),
      .rd_en        (rd_en),
      .rd_data      (rd_data),
      .empty        (empty),
      .rd_error     (rd_error),
      .rd_corrected (rd_corrected),
      .flip_mask    (flip_mask)
   );

   typedef struct {
      logic [DW-1:0] data;
      int            flips;
      string         tag;
   } exp_t;

   exp_t          sb[$];
   logic [DW-1:0] mdl[$];
   bit            exp_rd = 1'b0;
   int            n_chk = 0;
   int            n_fail = 0;
   bit            done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: called at a falling edge, returns at the next falling edge with idle inputs
   task automatic cyc(input bit w, input logic [DW-1:0] d, input bit r,
                      input logic [CW-1:0] m, input string tag);
      bit was_full, was_empty;
      exp_t it;
      was_full  = (mdl.size() == DEPTH);
      was_empty = (mdl.size() == 0);
      wr_en = w; wr_data = d; rd_en = r; flip_mask = m;
      exp_rd = 1'b0;
      if (r && !was_empty) begin
         it.data  = mdl.pop_front();
         it.flips = $countones(m);
         it.tag   = tag;
         sb.push_back(it);
         exp_rd = 1'b1;
      end
      if (w && !was_full) mdl.push_back(d);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; flip_mask = '0; exp_rd = 1'b0;
   endtask

   // monitor: compares read results one edge after the accepted read
   initial begin
      bit   pend;
      exp_t it;
      forever begin
         @(posedge clk);
         pend = exp_rd;
         @(negedge clk);
         if (pend) begin
            it = sb.pop_front();
            if (it.flips >= 2) begin
               chk(rd_error == 1'b1 && rd_corrected == 1'b0, {it.tag, " flags"},
                   {30'd0, rd_error, rd_corrected}, 32'h2);
            end else begin
               chk(rd_data == it.data, {it.tag, " data"}, 32'(rd_data), 32'(it.data));
               chk(rd_error == 1'b0 && rd_corrected == (it.flips == 1), {it.tag, " flags"},
                   {30'd0, rd_error, rd_corrected}, (it.flips == 1) ? 32'h1 : 32'h0);
            end
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] held;
      logic          he, hc;

      // R1 reset state
      repeat (3) @(negedge clk);
      chk(empty && !full && rd_data == '0 && !rd_error && !rd_corrected, "R1 in reset",
          {27'd0, empty, full, rd_error, rd_corrected, |rd_data}, 32'h10);
      rst_n = 1'b1;
      @(negedge clk);
      chk(empty && !full && rd_data == '0 && !rd_error && !rd_corrected, "R1 after release",
          {27'd0, empty, full, rd_error, rd_corrected, |rd_data}, 32'h10);

      // R2 / R7 / R5: clean word, empty drops after write, one-edge latency and hold
      cyc(1, 8'hA5, 0, '0, "R2");
      chk(!empty, "R7 empty falls after write", 32'(empty), 0);
      cyc(0, '0, 1, '0, "R2 clean read R5 latency");
      held = rd_data;
      cyc(0, '0, 0, '0, "idle");
      cyc(1, 8'h3C, 0, '0, "write");
      chk(rd_data == held && !rd_error && !rd_corrected, "R5 hold without read",
          32'(rd_data), 32'(held));
      cyc(0, '0, 1, '0, "R2 second clean read");

      // R3: single flip at each stored position
      for (int i = 0; i < CW; i++) begin
         cyc(1, 8'(8'h5A ^ (i * 37)), 0, '0, "write");
         cyc(0, '0, 1, CW'(1) << i, $sformatf("R3 flip bit %0d", i));
      end

      // R4: two flips at mixed positions
      for (int i = 0; i < 6; i++) begin
         int a, b;
         a = (i * 5) % CW;
         b = (i * 5 + 1 + i) % CW;
         cyc(1, 8'(8'hC3 + i * 11), 0, '0, "write");
         cyc(0, '0, 1, (CW'(1) << a) | (CW'(1) << b), $sformatf("R4 flips %0d,%0d", a, b));
      end

      // R11: mask present on writes and idle cycles only
      cyc(1, 8'h81, 0, 13'h1FFF, "write under mask");
      cyc(0, '0, 0, 13'h0421, "idle under mask");
      cyc(0, '0, 1, '0, "R11 mask outside read ignored");

      // R6: fill
      for (int i = 0; i < DEPTH; i++) begin
         cyc(1, 8'(i * 7 + 1), 0, '0, "fill");
         if (i == DEPTH - 2) chk(!full, "R6 not full at DEPTH-1", 32'(full), 0);
      end
      chk(full && !empty, "R6 full at DEPTH", {30'd0, full, empty}, 32'h2);

      // R8: write while full dropped
      cyc(1, 8'hEE, 0, '0, "write while full");
      chk(full, "R8 still full", 32'(full), 1);
      for (int i = 0; i < DEPTH; i++) begin
         cyc(0, '0, 1, '0, "R8 drain order");
      end
      chk(empty && !full, "R7 empty after draining", {30'd0, full, empty}, 32'h1);

      // R9: read while empty dropped
      held = rd_data; he = rd_error; hc = rd_corrected;
      cyc(0, '0, 1, 13'h0003, "read while empty");
      cyc(0, '0, 1, '0, "read while empty");
      chk(rd_data == held && rd_error == he && rd_corrected == hc && empty,
          "R9 outputs hold", 32'(rd_data), 32'(held));
      cyc(1, 8'h77, 0, '0, "write");
      cyc(0, '0, 1, '0, "R9 next write is next read");

      // R10: combined read and write keeps occupancy
      cyc(1, 8'h10, 0, '0, "write");
      cyc(1, 8'h11, 0, '0, "write");
      cyc(1, 8'h12, 0, '0, "write");
      for (int i = 0; i < 10; i++) begin
         cyc(1, 8'(8'h20 + i), 1, '0, "R10 combined");
         chk(!empty && !full, "R10 occupancy flags", {30'd0, full, empty}, 0);
      end
      cyc(0, '0, 1, '0, "R10 drain");
      cyc(0, '0, 1, '0, "R10 drain");
      chk(!empty, "R10 one word left", 32'(empty), 0);
      cyc(0, '0, 1, '0, "R10 drain");
      chk(empty, "R10 empty after three reads", 32'(empty), 1);

      @(negedge clk);
      chk(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule